// File: doc/BRIEF.md
# Pin Pull-Resistor Strap Detector

This block finds out, after a start pulse, which of three board pins carry an external pull-up or pull-down resistor. A boot controller reads the result to choose where to load code from. For each pin it runs two probes. It drives the pin to one level, lets it float, waits long enough for any resistor to pull the pin over, and then samples it. The first probe drives low, so a pull-up shows up as a high sample. The second probe drives high, so a pull-down shows up as a low sample.

The pins are probed one after another in a fixed order. The detector drives the pads through a per-pin output-enable and output-value pair, and it reads a per-pin input sample. The drive time and the float time come from a clock-frequency parameter and two durations in nanoseconds. Each is rounded so that it is always strictly longer than the minimum it stands for.

A pull-up on the data pin points to the serial boot source. A pull-up on the chip-select pin points to flash, and a pull-up on the clock pin points to an SD card. A pin with no strap follows the last level that was driven onto it, so both of its bits stay clear.

Top module: `strap_detect`

## Requirements
- R1: After reset all output enables and output values are 0, the done flag is 0 and both masks are 0.
- R2: Each drive interval lasts floor(CLK_HZ·DRIVE_NS/1e9)+1 cycles and each float interval lasts floor(CLK_HZ·SETTLE_NS/1e9)+1 cycles. With the defaults of 200 MHz, 1000 ns and 5000 ns these are 201 and 1001 cycles.
- R3: The pull-up probe drives the pin low, releases it, and samples it on the last float cycle. A high sample sets that pin's bit in the pull-up mask, and a low sample clears it.
- R4: The pull-down probe drives the pin high, releases it, and samples it on the last float cycle. A low sample sets that pin's bit in the pull-down mask, and a high sample clears it.
- R5: The pins are probed in the order data (index 0), chip-select (index 2), clock (index 1). Each pin gets its pull-up probe and then its pull-down probe. Pad vector bit i and mask bit i both refer to pin index i.
- R6: At most one output enable is high at a time. An output value bit is 1 only while its enable is high and the probe level is high, and it is 0 at all other times.
- R7: A pin that reads low after the low drive and high after the high drive has both of its mask bits clear.
- R8: The done flag rises on the clock edge that captures the final sample. It then stays high, with both masks and all pad outputs unchanged and released, until a start is taken.
- R9: A start seen while idle or done clears done and both masks at the next edge and begins the sequence. A start seen while a sequence is running has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Starts a detection run when the block is idle or done |
| pad_oe_o | output | 3 | Per-pin output enable, bit i is pin index i |
| pad_out_o | output | 3 | Per-pin driven value |
| pad_in_i | input | 3 | Per-pin sampled input level |
| done_o | output | 1 | Detection results valid |
| pullup_mask_o | output | 3 | 1 where a pull-up was found |
| pulldown_mask_o | output | 3 | 1 where a pull-down was found |

## Verification
The bound checker watches pad discipline on every cycle: one enable at most, and no driven value without its enable. It also checks the exact length of every drive interval, that the masks hold while done is high, and that a start taken in the done state clears the results. Only the bench scenarios can show the things that depend on the pad model. These are the float length measured against a pull that settles just under the required time, the probe order across the three pins, whether the pull-down bit truly comes from a low sample, and that a start during a run is ignored. The bench shows these through different strap patterns on each pin.

// File: rtl/strap_pkg.sv
package strap_pkg;

    localparam int PIN_COUNT = 3;
    localparam int PIN_W     = 2;
    localparam int STEP_W    = 2;

    // pin indices; mask bit i belongs to pin index i
    localparam logic [PIN_W-1:0] PIN_DATA = 2'd0;
    localparam logic [PIN_W-1:0] PIN_CLK  = 2'd1;
    localparam logic [PIN_W-1:0] PIN_CS   = 2'd2;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_DRIVE = 2'd1,
        PH_FLOAT = 2'd2,
        PH_DONE  = 2'd3
    } phase_e;

    typedef struct packed {
        phase_e              phase;
        logic [STEP_W-1:0]   step;   // position in the probe order
        logic                level;  // 0: pull-up probe, 1: pull-down probe
    } seq_state_t;

    // probe order: data, chip-select, clock
    function automatic logic [PIN_W-1:0] probe_pin(input logic [STEP_W-1:0] step);
        case (step)
            2'd0:    return PIN_DATA;
            2'd1:    return PIN_CS;
            default: return PIN_CLK;
        endcase
    endfunction

    // smallest cycle count strictly longer than ns at hz
    function automatic int unsigned hold_cycles(input longint unsigned hz,
                                                input longint unsigned ns);
        longint unsigned whole;
        whole = (hz * ns) / 64'd1_000_000_000;
        return int'(whole) + 1;
    endfunction

endpackage

// File: rtl/strap_timer.sv
module strap_timer #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             restart,
    input  logic [CNT_W-1:0] limit,
    output logic             expire
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expire = run && (cnt == (limit - 1'b1));
endmodule

// File: rtl/strap_sequencer.sv
module strap_sequencer
    import strap_pkg::*;
#(
    parameter int DRIVE_CYC  = 201,
    parameter int SETTLE_CYC = 1001
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    output seq_state_t st,
    output logic       capture,
    output logic       clear
);
    localparam int MAX_CYC = (DRIVE_CYC > SETTLE_CYC) ? DRIVE_CYC : SETTLE_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] DRV_LIM = CNT_W'(DRIVE_CYC);
    localparam logic [CNT_W-1:0] SET_LIM = CNT_W'(SETTLE_CYC);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(PIN_COUNT - 1);

    logic             busy;
    logic             expire;
    logic             restart;
    logic [CNT_W-1:0] limit;
    seq_state_t       st_nxt;

    assign busy    = (st.phase == PH_DRIVE) || (st.phase == PH_FLOAT);
    assign clear   = start && !busy;
    assign limit   = (st.phase == PH_DRIVE) ? DRV_LIM : SET_LIM;
    assign restart = clear || expire;
    assign capture = (st.phase == PH_FLOAT) && expire;

    strap_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (busy),
        .restart (restart),
        .limit   (limit),
        .expire  (expire)
    );

    always_comb begin
        st_nxt = st;
        case (st.phase)
            PH_IDLE, PH_DONE: begin
                if (start) begin
                    st_nxt.phase = PH_DRIVE;
                    st_nxt.step  = '0;
                    st_nxt.level = 1'b0;
                end
            end
            PH_DRIVE: begin
                if (expire) st_nxt.phase = PH_FLOAT;
            end
            PH_FLOAT: begin
                if (expire) begin
                    if (!st.level) begin
                        st_nxt.phase = PH_DRIVE;
                        st_nxt.level = 1'b1;
                    end else if (st.step == LAST_STEP) begin
                        st_nxt.phase = PH_DONE;
                    end else begin
                        st_nxt.phase = PH_DRIVE;
                        st_nxt.step  = st.step + 1'b1;
                        st_nxt.level = 1'b0;
                    end
                end
            end
            default: st_nxt.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st.phase <= PH_IDLE;
            st.step  <= '0;
            st.level <= 1'b0;
        end else begin
            st <= st_nxt;
        end
    end
endmodule

// File: rtl/strap_pad_ctl.sv
module strap_pad_ctl
    import strap_pkg::*;
(
    input  seq_state_t           st,
    output logic [PIN_COUNT-1:0] pad_oe,
    output logic [PIN_COUNT-1:0] pad_out
);
    logic [PIN_W-1:0] cur_pin;
    assign cur_pin = probe_pin(st.step);

    for (genvar i = 0; i < PIN_COUNT; i++) begin : g_pad
        assign pad_oe[i]  = (st.phase == PH_DRIVE) && (cur_pin == PIN_W'(i));
        assign pad_out[i] = pad_oe[i] && st.level;
    end
endmodule

// File: rtl/strap_mask_bank.sv
module strap_mask_bank
    import strap_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clear,
    input  logic                 capture,
    input  seq_state_t           st,
    input  logic [PIN_COUNT-1:0] pad_in,
    output logic [PIN_COUNT-1:0] up_mask,
    output logic [PIN_COUNT-1:0] dn_mask
);
    logic [PIN_W-1:0] cur_pin;
    assign cur_pin = probe_pin(st.step);

    for (genvar i = 0; i < PIN_COUNT; i++) begin : g_bit
        logic hit;
        assign hit = capture && (cur_pin == PIN_W'(i));

        always_ff @(posedge clk) begin
            if (rst || clear) begin
                up_mask[i] <= 1'b0;
                dn_mask[i] <= 1'b0;
            end else if (hit) begin
                if (!st.level) up_mask[i] <= pad_in[i];   // high after low drive
                else           dn_mask[i] <= !pad_in[i];  // low after high drive
            end
        end
    end
endmodule

// File: rtl/strap_detect.sv
module strap_detect
    import strap_pkg::*;
#(
    parameter longint unsigned CLK_HZ    = 200_000_000,
    parameter longint unsigned DRIVE_NS  = 1000,
    parameter longint unsigned SETTLE_NS = 5000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    output logic [2:0] pad_oe_o,
    output logic [2:0] pad_out_o,
    input  logic [2:0] pad_in_i,
    output logic       done_o,
    output logic [2:0] pullup_mask_o,
    output logic [2:0] pulldown_mask_o
);
    localparam int DRIVE_CYC  = hold_cycles(CLK_HZ, DRIVE_NS);
    localparam int SETTLE_CYC = hold_cycles(CLK_HZ, SETTLE_NS);

    seq_state_t st;
    logic       capture;
    logic       clear;

    strap_sequencer #(
        .DRIVE_CYC  (DRIVE_CYC),
        .SETTLE_CYC (SETTLE_CYC)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start_i),
        .st      (st),
        .capture (capture),
        .clear   (clear)
    );

    strap_pad_ctl u_pad (
        .st      (st),
        .pad_oe  (pad_oe_o),
        .pad_out (pad_out_o)
    );

    strap_mask_bank u_mask (
        .clk     (clk),
        .rst     (rst),
        .clear   (clear),
        .capture (capture),
        .st      (st),
        .pad_in  (pad_in_i),
        .up_mask (pullup_mask_o),
        .dn_mask (pulldown_mask_o)
    );

    assign done_o = (st.phase == PH_DONE);
endmodule

// File: rtl/strap_detect_chk.sv
module strap_detect_chk
    import strap_pkg::*;
#(
    parameter longint unsigned CLK_HZ   = 200_000_000,
    parameter longint unsigned DRIVE_NS = 1000
) (
    input logic       clk,
    input logic       rst,
    input logic       start_i,
    input logic [2:0] pad_oe_o,
    input logic [2:0] pad_out_o,
    input logic       done_o,
    input logic [2:0] pullup_mask_o,
    input logic [2:0] pulldown_mask_o
);
    localparam int EXP_DRV = hold_cycles(CLK_HZ, DRIVE_NS);

    int unsigned drv_len;
    always_ff @(posedge clk) begin
        if (rst)            drv_len <= 0;
        else if (|pad_oe_o) drv_len <= drv_len + 1;
        else                drv_len <= 0;
    end

    a_r6_one_enable: assert property (@(posedge clk) disable iff (rst)
        $onehot0(pad_oe_o) && ((pad_out_o & ~pad_oe_o) == 3'b000));

    a_r2_drive_length: assert property (@(posedge clk) disable iff (rst)
        $fell(|pad_oe_o) |-> (drv_len == EXP_DRV));

    a_r8_results_hold: assert property (@(posedge clk) disable iff (rst)
        (done_o && !start_i) |=> (done_o && $stable(pullup_mask_o) && $stable(pulldown_mask_o)));

    a_r8_released_when_done: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (pad_oe_o == 3'b000));

    a_r9_restart_clears: assert property (@(posedge clk) disable iff (rst)
        (done_o && start_i) |=> (!done_o && pullup_mask_o == 3'b000 && pulldown_mask_o == 3'b000));
endmodule

bind strap_detect strap_detect_chk #(
    .CLK_HZ   (CLK_HZ),
    .DRIVE_NS (DRIVE_NS)
) u_strap_chk (
    .clk             (clk),
    .rst             (rst),
    .start_i         (start_i),
    .pad_oe_o        (pad_oe_o),
    .pad_out_o       (pad_out_o),
    .done_o          (done_o),
    .pullup_mask_o   (pullup_mask_o),
    .pulldown_mask_o (pulldown_mask_o)
);

// File: tb/test_strap_detect.sv
`timescale 1ns/1ps
module test_strap_detect;
    localparam int DRV = 201;    // 1 us at 200 MHz, plus one
    localparam int SET = 1001;   // 5 us at 200 MHz, plus one
    localparam int PULL_DLY = 1000;  // pull reaches the rail 5 us after release
    localparam int ST_NONE = 0, ST_UP = 1, ST_DN = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [2:0] oe, outv, pin_in, up, dn;
    logic       done;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    strap_detect i_strap_detect (
        .clk             (clk),
        .rst             (rst),
        .start_i         (start),
        .pad_oe_o        (oe),
        .pad_out_o       (outv),
        .pad_in_i        (pin_in),
        .done_o          (done),
        .pullup_mask_o   (up),
        .pulldown_mask_o (dn)
    );

    // resolved pad model: driven level, else slow pull, else held charge
    int   strap [3];
    int   flt   [3];
    logic [2:0] last_drv;

    always_ff @(posedge clk) begin
        for (int i = 0; i < 3; i++) begin
            if (rst) begin
                last_drv[i] <= 1'b0;
                flt[i]      <= PULL_DLY;
            end else if (oe[i]) begin
                last_drv[i] <= outv[i];
                flt[i]      <= 0;
            end else if (flt[i] < PULL_DLY) begin
                flt[i] <= flt[i] + 1;
            end
        end
    end

    always_comb begin
        for (int i = 0; i < 3; i++) begin
            if (oe[i])                                   pin_in[i] = outv[i];
            else if (strap[i] != ST_NONE && flt[i] >= PULL_DLY) pin_in[i] = (strap[i] == ST_UP);
            else                                         pin_in[i] = last_drv[i];
        end
    end

    task automatic cmp(input logic [2:0] e_oe, input logic [2:0] e_out, input logic e_done,
                       input logic [2:0] e_up, input logic [2:0] e_dn, input string ctx);
        n_tests++;
        if (oe !== e_oe || outv !== e_out) begin
            n_fail++;
            if (n_fail <= 20)
                $display("FAIL R2/R5/R6 %s pads: oe=%b out=%b expected oe=%b out=%b at %0t",
                         ctx, oe, outv, e_oe, e_out, $time);
        end
        n_tests++;
        if (done !== e_done || up !== e_up || dn !== e_dn) begin
            n_fail++;
            if (n_fail <= 20)
                $display("FAIL R3/R4/R7/R8/R9 %s results: done=%b up=%b dn=%b expected done=%b up=%b dn=%b at %0t",
                         ctx, done, up, dn, e_done, e_up, e_dn, $time);
        end
    endtask

    // reference sequence: cycle-by-cycle expectation of one run
    task automatic run_probe(input int s_data, input int s_clk, input int s_cs,
                             input int mid_start, input string ctx);
        int order [3] = '{0, 2, 1};   // R5 probe order by pin index
        logic [2:0] e_up = 3'b000;
        logic [2:0] e_dn = 3'b000;
        strap[0] = s_data; strap[1] = s_clk; strap[2] = s_cs;
        fork
            begin
                @(negedge clk); start = 1'b1;
                @(negedge clk); start = 1'b0;
                // R9: first cycle of a new run has cleared results
                for (int st = 0; st < 3; st++) begin
                    int p = order[st];
                    for (int lvl = 0; lvl < 2; lvl++) begin
                        logic [2:0] hot = 3'b001 << p;
                        for (int k = 0; k < DRV; k++) begin
                            cmp(hot, (lvl == 1) ? hot : 3'b000, 1'b0, e_up, e_dn, ctx);
                            @(negedge clk);
                        end
                        for (int k = 0; k < SET; k++) begin
                            cmp(3'b000, 3'b000, 1'b0, e_up, e_dn, ctx);
                            @(negedge clk);
                        end
                        if (lvl == 0) e_up[p] = (strap[p] == ST_UP);   // R3
                        else          e_dn[p] = (strap[p] == ST_DN);   // R4, R7
                    end
                end
                // R8: done with stable results until next start
                for (int k = 0; k < 20; k++) begin
                    cmp(3'b000, 3'b000, 1'b1, e_up, e_dn, ctx);
                    @(negedge clk);
                end
            end
            begin
                if (mid_start > 0) begin
                    repeat (mid_start) @(negedge clk);
                    start = 1'b1;   // R9: ignored while running
                    @(negedge clk);
                    start = 1'b0;
                end
            end
        join
    endtask

    initial begin
        strap[0] = ST_NONE; strap[1] = ST_NONE; strap[2] = ST_NONE;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1: reset state holds while idle
        for (int k = 0; k < 5; k++) begin
            cmp(3'b000, 3'b000, 1'b0, 3'b000, 3'b000, "R1 reset");
            @(negedge clk);
        end
        run_probe(ST_UP,   ST_NONE, ST_DN,   0,    "mixed serial");
        run_probe(ST_UP,   ST_UP,   ST_UP,   0,    "all pull-up");
        run_probe(ST_DN,   ST_DN,   ST_DN,   1900, "all pull-down, start mid-run R9");
        run_probe(ST_NONE, ST_NONE, ST_NONE, 300,  "no strap R7");
        run_probe(ST_DN,   ST_UP,   ST_NONE, 0,    "sd boot");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #1_000_000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual hung expected complete");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule